// File: doc/BRIEF.md
# I/O Register Single-Bit Set/Clear Sequencer

This block carries out single-bit set and clear instructions on the lowest 32 registers of a microcontroller's I/O space. Each 16-bit instruction word arrives on a valid/ready stream. The block decodes the word and pulls out a 5-bit register address and a 3-bit bit index. It then runs a read-modify-write on a plain I/O bus: one cycle reads the register, and the next cycle writes it back with only the chosen bit forced. The status flags of the core are neither connected to the block nor changed by it.

The instruction stream follows the usual rules. A word transfers on a rising edge where `instr_valid` and `instr_ready` are both high. The upstream side must hold `instr_word` steady while `instr_valid` is high and `instr_ready` is low. `instr_ready` drops only for the read cycle of an operation, and `busy` mirrors that cycle. A new word can therefore be accepted during the write-back cycle, and its read follows directly after that write. Back-to-back operations thus complete one every two cycles. A word that is neither instruction is still consumed, but it causes no bus activity at all.

Top module: `io_bitmod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `io_rd`, `io_wr` and `busy` are low and `instr_ready` is high.
- R2: A word whose bits [15:8] are 8'b1001_1010 is a set instruction. It forces bit `word[2:0]` of register `word[7:3]` to 1.
- R3: A word whose bits [15:8] are 8'b1001_1000 is a clear instruction. It forces bit `word[2:0]` of register `word[7:3]` to 0.
- R4: The write-back data equals the data read one cycle before, except at the selected bit index.
- R5: In the cycle after a set or clear word is accepted, `io_rd` is high with `io_addr` = `word[7:3]`. In that same cycle `busy` is high and `instr_ready` is low.
- R6: In the cycle after the read, `io_wr` is high at the same `io_addr`, and `busy` is low.
- R7: Any other word is accepted and dropped. `io_rd`, `io_wr` and `busy` stay low, and the register contents are unchanged.
- R8: A word offered during a write-back cycle is accepted at once. Its read happens in the next cycle and returns the value that was just written.
- R9: `io_rd` and `io_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block can take a word this cycle |
| instr_word | input | 16 | Instruction word |
| busy | output | 1 | High during the read cycle of an operation |
| io_addr | output | 5 | I/O register address |
| io_rd | output | 1 | Read strobe; data returned on `io_rdata` in the same cycle |
| io_rdata | input | 8 | Read data from the addressed register |
| io_wr | output | 1 | Write strobe; register loads `io_wdata` at the rising edge |
| io_wdata | output | 8 | Write-back data |

## Verification
A corrupted latched address or bit index shows up two cycles after acceptance. The write then lands at a different register, or changes a bit other than the one named, and the register array no longer matches. A sequencer state stuck or skipped shows up within one cycle: a read with no write behind it, a strobe on an ignored word, or `instr_ready` high during a read. A wrong captured data value shows up on `io_wdata` in the write cycle. It also shows up in the next read of a back-to-back pair on the same register.

// File: rtl/io_bitmod_pkg.sv
package io_bitmod_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 5;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 1 << IDX_W;
  localparam int OPC_W   = INSTR_W - ADDR_W - IDX_W - 2;
  localparam logic [OPC_W-1:0] OPC_BITOP = 6'b100110;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              hit;
    logic              set_op;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
  } bitop_t;
endpackage

// File: rtl/io_bitmod_decode.sv
module io_bitmod_decode
  import io_bitmod_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output bitop_t             op
);
  localparam int SEL_BIT = IDX_W + ADDR_W;
  localparam int KIND_BIT = SEL_BIT + 1;

  always_comb begin
    op.hit    = (word[INSTR_W-1:KIND_BIT+1] == OPC_BITOP) && !word[SEL_BIT];
    op.set_op = word[KIND_BIT];
    op.addr   = word[SEL_BIT-1:IDX_W];
    op.idx    = word[IDX_W-1:0];
  end
endmodule

// File: rtl/io_bitmod_merge.sv
module io_bitmod_merge
  import io_bitmod_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  idx,
  input  logic              set_op,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dout[i] = (idx == IDX_W'(i)) ? set_op : din[i];
  end
endmodule

// File: rtl/io_bitmod_seq.sv
module io_bitmod_seq
  import io_bitmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  bitop_t            dec,
  output logic              instr_ready,
  output logic              busy,
  output logic              io_rd,
  output logic              io_wr,
  output logic [ADDR_W-1:0] io_addr,
  output logic [IDX_W-1:0]  idx_q,
  output logic              set_q
);
  seq_state_e state_q, state_d;
  logic       take;

  assign instr_ready = (state_q != ST_READ);
  assign take        = instr_valid && instr_ready;

  always_comb begin
    state_d = ST_IDLE;
    if (state_q == ST_READ)
      state_d = ST_WRITE;
    else if (take && dec.hit)
      state_d = ST_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      io_addr <= '0;
      idx_q   <= '0;
      set_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take && dec.hit) begin
        io_addr <= dec.addr;
        idx_q   <= dec.idx;
        set_q   <= dec.set_op;
      end
    end
  end

  assign busy  = (state_q == ST_READ);
  assign io_rd = (state_q == ST_READ);
  assign io_wr = (state_q == ST_WRITE);
endmodule

// File: rtl/io_bitmod.sv
module io_bitmod
  import io_bitmod_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               busy,
  output logic [ADDR_W-1:0]  io_addr,
  output logic               io_rd,
  input  logic [DATA_W-1:0]  io_rdata,
  output logic               io_wr,
  output logic [DATA_W-1:0]  io_wdata
);
  bitop_t             dec;
  logic [IDX_W-1:0]   idx_q;
  logic               set_q;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  wdata_q;

  io_bitmod_decode u_decode (
    .word (instr_word),
    .op   (dec)
  );

  io_bitmod_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .dec         (dec),
    .instr_ready (instr_ready),
    .busy        (busy),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .idx_q       (idx_q),
    .set_q       (set_q)
  );

  io_bitmod_merge u_merge (
    .din    (io_rdata),
    .idx    (idx_q),
    .set_op (set_q),
    .dout   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wdata_q <= '0;
    else if (io_rd) wdata_q <= merged;
  end

  assign io_wdata = wdata_q;
endmodule

// File: rtl/io_bitmod_chk.sv
module io_bitmod_chk
  import io_bitmod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_ready,
  input logic              busy,
  input logic              io_rd,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_rdata,
  input logic [DATA_W-1:0] io_wdata
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr)); // R9
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> io_wr); // R6
  AST_WR_HAS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> $past(io_rd)); // R6
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> io_addr == $past(io_addr)); // R6
  AST_ONE_BIT_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> $countones(io_wdata ^ $past(io_rdata)) <= 1); // R4
  AST_NO_TAKE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> (busy && !instr_ready)); // R5
  AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> (!busy && instr_ready)); // R8
endmodule

bind io_bitmod io_bitmod_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .busy        (busy),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_addr     (io_addr),
  .io_rdata    (io_rdata),
  .io_wdata    (io_wdata)
);

// File: tb/io_bitmod_bench.sv
`timescale 1ns/1ps
module io_bitmod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0;
  logic        busy;
  logic [4:0]  io_addr;
  logic        io_rd;
  logic [7:0]  io_rdata;
  logic        io_wr;
  logic [7:0]  io_wdata;

  logic [7:0]  mem [32];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  assign io_rdata = mem[io_addr];
  always @(posedge clk) if (io_wr) mem[io_addr] <= io_wdata;

  io_bitmod u_io_bitmod (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .busy(busy), .io_addr(io_addr), .io_rd(io_rd),
    .io_rdata(io_rdata), .io_wr(io_wr), .io_wdata(io_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // offer a word at a falling edge and return at the falling edge after transfer
  task automatic send(input logic [15:0] w);
    instr_word  = w;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    @(negedge clk);
    chk(!io_rd && !io_wr && !busy && instr_ready, "R1 in reset", {io_rd, io_wr, busy, instr_ready}, 4'b0001);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!io_rd && !io_wr && !busy && instr_ready, "R1 after reset", {io_rd, io_wr, busy, instr_ready}, 4'b0001);

    // R2 R3 R4 R5 R6: sweep every address, bit and kind
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int k = 0; k < 2; k++) begin
          logic [7:0] pre, exp;
          logic [15:0] w;
          pre = 8'((a * 37) ^ (b * 91) ^ (k * 170) ^ 8'h5C);
          mem[a] = pre;
          exp = k ? (pre | 8'(1 << b)) : (pre & ~8'(1 << b));
          w = {k ? 8'h9A : 8'h98, 5'(a), 3'(b)};
          send(w);
          chk(io_rd && busy && !instr_ready && io_addr == 5'(a), "R5 read cycle", {io_rd, busy, instr_ready, 3'b0, io_addr}, {3'b110, 3'b0, 5'(a)});
          @(negedge clk);
          chk(io_wr && !busy && io_addr == 5'(a), "R6 write cycle", {io_wr, busy, 6'b0, io_addr}, {2'b10, 6'b0, 5'(a)});
          chk(io_wdata == exp, k ? "R2 set data" : "R3 clear data", io_wdata, exp);
          @(negedge clk);
          chk(mem[a] == exp, "R4 register after write", mem[a], exp);
        end
      end
    end

    // R7: words that match neither pattern
    for (int u = 0; u < 4; u++) begin
      for (int j = 0; j < 256; j += 7) begin
        logic [7:0] hi;
        logic [15:0] w;
        case (u)
          0: hi = 8'h9B;
          1: hi = 8'h99;
          2: hi = 8'hDA;
          default: hi = 8'h1A;
        endcase
        w = {hi, 8'(j)};
        mem[j[7:3]] = 8'hA5;
        send(w);
        chk(!io_rd && !busy && instr_ready, "R7 no read", {io_rd, busy, instr_ready}, 3'b001);
        @(negedge clk);
        chk(!io_wr && mem[j[7:3]] == 8'hA5, "R7 no write", {io_wr, mem[j[7:3]]}, {1'b0, 8'hA5});
      end
    end

    // R8: second word offered during write-back, same register
    mem[5] = 8'h00;
    instr_word = {8'h9A, 5'd5, 3'd0};
    instr_valid = 1'b1;
    @(negedge clk);
    chk(io_rd && !instr_ready, "R8 first read", {io_rd, instr_ready}, 2'b10);
    instr_word = {8'h9A, 5'd5, 3'd1};
    @(negedge clk);
    chk(io_wr && instr_ready && io_wdata == 8'h01, "R8 first write", {io_wr, instr_ready, io_wdata}, {2'b11, 8'h01});
    @(negedge clk);
    instr_valid = 1'b0;
    chk(io_rd && busy && io_rdata == 8'h01, "R8 second read sees write", {io_rd, busy, io_rdata}, {2'b11, 8'h01});
    @(negedge clk);
    chk(io_wr && io_wdata == 8'h03, "R8 second write", {io_wr, io_wdata}, {1'b1, 8'h03});
    @(negedge clk);
    chk(mem[5] == 8'h03 && !io_rd && !io_wr, "R8 final", mem[5], 8'h03);

    // R9: rd and wr never together over a clear pair
    instr_word = {8'h98, 5'd5, 3'd0};
    instr_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (c == 1) instr_word = {8'h98, 5'd5, 3'd1};
      if (c == 2) instr_valid = 1'b0;
      chk(!(io_rd && io_wr), "R9 strobes exclusive", {io_rd, io_wr}, 2'b00);
    end
    @(negedge clk);
    chk(mem[5] == 8'h00, "R3 back-to-back clear", mem[5], 8'h00);
    finish_run();
  end
endmodule